// File: doc/BRIEF.md
# Input Capture Channel With Coherent Byte Read

This block is one timer channel working as an input capture unit. An external pin is brought into the clock domain through a short synchronizer. The edge detector then compares the synchronized level with its value one cycle earlier. When the selected edge appears, the block copies the current value of a shared free-running counter into a capture register. In the same cycle it sets a channel flag, and that flag can drive an interrupt line when the interrupt is enabled.

Software reads the capture value one byte at a time over an 8-bit bus. Reading either byte first freezes the opposite byte in a one-byte holding buffer. The second read returns that frozen byte, so the two bytes always belong to the same capture, in either access order. A write to the channel's control address abandons a half-finished read sequence. The counter may be stopped for debugging and capture still works: the register simply receives the held count.

Top module: `icap_channel`

## Requirements
- R1: A pin change that the clock samples at edge k is seen as a capture at edge k+2. After that edge the capture register holds the count_i value that was present at edge k+2.
- R2: edge_sel_i picks the active edge: 2'b00 none, 2'b01 rising only, 2'b10 falling only, 2'b11 either edge. A transition of a kind that is not selected leaves the capture register and the flag unchanged.
- R3: Bus writes to the capture byte addresses (1 = high byte, 2 = low byte) and to address 3 do not change the capture register.
- R4: When no read sequence is open, a read of either byte returns that byte of the capture register and freezes the other byte. The next read of the other byte returns the frozen value and closes the sequence. This holds for both high-first and low-first order.
- R5: A bus write to address 0 (control) closes any open read sequence. The following read of either byte returns the live capture register byte.
- R6: Each capture sets flag_o. A pulse on flag_clr_i clears it. When a capture and a clear happen in the same cycle, the flag stays set.
- R7: irq_o is high exactly when flag_o is high and irq_en_i is high.
- R8: When count_i is held constant (counter frozen), every selected edge still captures that held value and sets the flag.
- R9: While a read sequence is open, a capture still updates the capture register. A repeated read of the byte that was read first returns the new value, the frozen byte stays as it was, and the new capture is fully visible once the sequence closes.
- R10: After reset the capture register is zero, the flag and the interrupt are low, no read sequence is open, and rdata_o is zero when rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous external capture pin |
| count_i | input | 16 | Shared timer counter value |
| edge_sel_i | input | 2 | Active edge select (none / rise / fall / both) |
| irq_en_i | input | 1 | Interrupt enable for the channel flag |
| rd_i | input | 1 | Bus read strobe |
| wr_i | input | 1 | Bus write strobe |
| addr_i | input | 2 | Byte address: 0 control, 1 capture high, 2 capture low |
| flag_clr_i | input | 1 | Clear strobe for the channel flag |
| rdata_o | output | 8 | Read data, valid while rd_i is high |
| flag_o | output | 1 | Channel capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default build: 8-bit bytes, a 16-bit count and a two-stage synchronizer. With these values it can sweep all four edge-select codes against both pin directions and compute each expected capture from the count sequence it drives itself. The short pipeline makes the two-cycle detection latency a single counted offset. The bench then runs both byte orders, reads interleaved with new captures, a control write in the middle of a sequence, and a frozen counter.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_CAP_HI = 2'd1,
        ADDR_CAP_LO = 2'd2,
        ADDR_RSVD   = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/icap_edge_detect.sv
module icap_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] edge_sel_i,
    output logic       cap_evt_o
);
    import icap_pkg::*;

    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_state_t;

    edge_state_t st_d, st_q;
    edge_sel_e   sel;
    logic        rise, fall;

    always_comb begin
        sel       = edge_sel_e'(edge_sel_i);
        st_d      = st_q;
        st_d.sync = {st_q.sync[TOP-1:0], pin_i};
        st_d.prev = st_q.sync[TOP];
        rise      = st_q.sync[TOP] & ~st_q.prev;
        fall      = ~st_q.sync[TOP] & st_q.prev;
        cap_evt_o = (rise && (sel == EDGE_RISE || sel == EDGE_BOTH))
                 || (fall && (sel == EDGE_FALL || sel == EDGE_BOTH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/icap_capture_reg.sv
module icap_capture_reg #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_evt_i,
    input  logic [2*BYTE_W-1:0] count_i,
    input  logic                rd_i,
    input  logic                wr_i,
    input  logic [1:0]          addr_i,
    output logic [BYTE_W-1:0]   rdata_o
);
    import icap_pkg::*;

    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cap;
        logic [BYTE_W-1:0] hold;
        logic              lock;
        logic              hold_is_lo;
    } cap_state_t;

    cap_state_t  st_d, st_q;
    reg_addr_e   addr;
    logic        hi_rd, lo_rd, ctrl_wr;
    logic [BYTE_W-1:0] cap_hi, cap_lo;

    always_comb begin
        addr    = reg_addr_e'(addr_i);
        hi_rd   = rd_i && (addr == ADDR_CAP_HI);
        lo_rd   = rd_i && (addr == ADDR_CAP_LO);
        ctrl_wr = wr_i && (addr == ADDR_CTRL);
        cap_hi  = st_q.cap[CNT_W-1:BYTE_W];
        cap_lo  = st_q.cap[BYTE_W-1:0];

        // read data path: frozen byte wins only for the byte not yet read
        if (hi_rd)
            rdata_o = (st_q.lock && !st_q.hold_is_lo) ? st_q.hold : cap_hi;
        else if (lo_rd)
            rdata_o = (st_q.lock && st_q.hold_is_lo) ? st_q.hold : cap_lo;
        else
            rdata_o = '0;

        st_d = st_q;
        if (cap_evt_i)
            st_d.cap = count_i;

        if (!st_q.lock) begin
            if (hi_rd) begin
                st_d.hold       = cap_lo;
                st_d.hold_is_lo = 1'b1;
                st_d.lock       = 1'b1;
            end else if (lo_rd) begin
                st_d.hold       = cap_hi;
                st_d.hold_is_lo = 1'b0;
                st_d.lock       = 1'b1;
            end
        end else if ((hi_rd && !st_q.hold_is_lo) || (lo_rd && st_q.hold_is_lo)) begin
            st_d.lock = 1'b0;
        end

        if (ctrl_wr)
            st_d.lock = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CAP_LOADS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt_i |=> (st_q.cap == $past(count_i)));                       // R1

    AST_CAP_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i != ADDR_CTRL && !cap_evt_i) |=> $stable(st_q.cap)); // R3

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> (!st_q.lock || $stable(st_q.hold)));                   // R9

    AST_CTRL_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !st_q.lock);                                              // R5

endmodule

// File: rtl/icap_flag.sv
module icap_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_evt_i,
    input  logic flag_clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);

    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_evt_i)       st_d.flag = 1'b1;
        else if (flag_clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & irq_en_i;

    AST_FLAG_SET_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt_i |=> flag_o);                                  // R6

    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !cap_evt_i) |=> !flag_o);                // R6

endmodule

// File: rtl/icap_channel.sv
module icap_channel #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [1:0]        edge_sel_i,
    input  logic              irq_en_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic              flag_clr_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              flag_o,
    output logic              irq_o
);

    logic cap_evt;

    icap_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .edge_sel_i (edge_sel_i),
        .cap_evt_o  (cap_evt)
    );

    icap_capture_reg #(.BYTE_W(BYTE_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_evt_i (cap_evt),
        .count_i   (count_i),
        .rd_i      (rd_i),
        .wr_i      (wr_i),
        .addr_i    (addr_i),
        .rdata_o   (rdata_o)
    );

    icap_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_evt_i  (cap_evt),
        .flag_clr_i (flag_clr_i),
        .irq_en_i   (irq_en_i),
        .flag_o     (flag_o),
        .irq_o      (irq_o)
    );

    AST_NO_READ_WRITE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |-> !wr_i);                                        // R4

endmodule

// File: tb/icap_channel_test.sv
module icap_channel_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 1'b0;
    logic [15:0] count = '0;
    logic [1:0]  edge_sel = 2'b00;
    logic        irq_en = 1'b0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        flag_clr = 1'b0;
    logic [7:0]  rdata;
    logic        flag, irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    icap_channel uut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .count_i(count),
        .edge_sel_i(edge_sel), .irq_en_i(irq_en), .rd_i(rd), .wr_i(wr),
        .addr_i(addr), .flag_clr_i(flag_clr), .rdata_o(rdata),
        .flag_o(flag), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic bus_wr(input logic [1:0] a);
        @(negedge clk); wr = 1'b1; addr = a;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic read_cap(output logic [15:0] v);
        logic [7:0] h, l;
        bus_rd(2'd1, h);
        bus_rd(2'd2, l);
        v = {h, l};
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    // pin changes before edge P1; capture happens at P3 with count = base + 2*step
    task automatic toggle(input logic newpin, input logic [15:0] base, input logic [15:0] step,
                          input logic clr_late, output logic flag_early);
        @(negedge clk); pin = newpin; count = base;
        @(negedge clk); count = base + step;
        @(negedge clk); count = base + 2*step; flag_early = flag; flag_clr = clr_late;
        @(negedge clk); flag_clr = 1'b0; count = base + 3*step;
    endtask

    initial begin
        #(CLK_P * 50000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v, prev, a_val, b_val, c_val, d_val, base;
        logic [7:0]  d8;
        logic        fe, hit;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 rdata idle", {8'h0, rdata}, 16'h0);
        chk("R10 flag", {15'h0, flag}, 16'h0);
        chk("R10 irq", {15'h0, irq}, 16'h0);
        read_cap(v);
        chk("R10 capture zero", v, 16'h0);

        // R1 R2 sweep of edge selects and directions
        for (int sel = 0; sel < 4; sel++) begin
            for (int dir = 0; dir < 2; dir++) begin
                edge_sel = 2'b00;
                @(negedge clk); pin = (dir == 1);
                repeat (4) @(negedge clk);
                clear_flag();
                read_cap(prev);
                edge_sel = sel[1:0];
                base = 16'h1357 + 16'(sel) * 16'h2211 + 16'(dir) * 16'h0806;
                toggle(dir == 0, base, 16'h1, 1'b0, fe);
                hit = (dir == 0) ? sel[0] : sel[1];
                chk("R1 flag not early", {15'h0, fe}, 16'h0);
                chk("R2 flag after edge", {15'h0, flag}, {15'h0, hit});
                read_cap(v);
                chk("R1 R2 captured value", v, hit ? base + 16'h2 : prev);
            end
        end

        edge_sel = 2'b11;

        // R7 interrupt gating (flag is set from last sweep step)
        irq_en = 1'b0; #1;
        chk("R7 irq masked", {15'h0, irq}, 16'h0);
        irq_en = 1'b1; #1;
        chk("R7 irq enabled", {15'h0, irq}, {15'h0, flag});
        clear_flag(); #1;
        chk("R7 irq after clear", {15'h0, irq}, 16'h0);
        chk("R6 flag cleared", {15'h0, flag}, 16'h0);

        // R6 capture wins over simultaneous clear
        toggle(~pin, 16'h4444, 16'h1, 1'b1, fe);
        chk("R6 capture beats clear", {15'h0, flag}, 16'h1);

        // R4 R9 coherency, high first
        toggle(~pin, 16'hA1B2, 16'h1, 1'b0, fe);
        a_val = 16'hA1B4;
        bus_rd(2'd1, d8);
        chk("R4 hi first live", {8'h0, d8}, {8'h0, a_val[15:8]});
        toggle(~pin, 16'h5C3D, 16'h1, 1'b0, fe);
        b_val = 16'h5C3F;
        bus_rd(2'd1, d8);
        chk("R9 reread first byte live", {8'h0, d8}, {8'h0, b_val[15:8]});
        bus_rd(2'd2, d8);
        chk("R4 lo from buffer", {8'h0, d8}, {8'h0, a_val[7:0]});
        // low first
        bus_rd(2'd2, d8);
        chk("R4 lo first live", {8'h0, d8}, {8'h0, b_val[7:0]});
        toggle(~pin, 16'h0F0E, 16'h1, 1'b0, fe);
        c_val = 16'h0F10;
        bus_rd(2'd1, d8);
        chk("R4 hi from buffer", {8'h0, d8}, {8'h0, b_val[15:8]});
        read_cap(v);
        chk("R9 capture updated while locked", v, c_val);

        // R5 control write releases the sequence
        bus_rd(2'd1, d8);
        toggle(~pin, 16'hE7C6, 16'h1, 1'b0, fe);
        d_val = 16'hE7C8;
        bus_wr(2'd0);
        bus_rd(2'd2, d8);
        chk("R5 live lo after ctrl write", {8'h0, d8}, {8'h0, d_val[7:0]});
        bus_rd(2'd1, d8);
        chk("R5 hi closes sequence", {8'h0, d8}, {8'h0, d_val[15:8]});

        // R3 writes ignored
        bus_wr(2'd1);
        bus_wr(2'd2);
        bus_wr(2'd3);
        read_cap(v);
        chk("R3 capture unchanged by writes", v, d_val);

        // R8 frozen counter
        clear_flag();
        toggle(~pin, 16'h7E81, 16'h0, 1'b0, fe);
        read_cap(v);
        chk("R8 frozen value", v, 16'h7E81);
        clear_flag();
        toggle(~pin, 16'h7E81, 16'h0, 1'b0, fe);
        chk("R8 flag on frozen capture", {15'h0, flag}, 16'h1);
        read_cap(v);
        chk("R8 frozen value again", v, 16'h7E81);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule